// File: doc/BRIEF.md
# Sixteen-bit ALU with Flag Register

This block is the execute stage of a small 16-bit integer datapath. It takes two source operands, a third operand holding the old destination value (used only by compare), a 4-bit operation code and a flag-write enable. It computes a 16-bit result and updates a three-bit carry/negative/zero flag register. Instruction decode, the register file, memory access and branching all sit outside the block.

The result, a result-write indicator and the three flags are all registered. The inputs presented before a rising clock edge appear on the outputs just after that edge. Add-with-carry reads the flag register as it stands, so it sees the carry left by the previous operation. Each operation follows its own flag rule. Arithmetic ops take C from the adder. Shifts take C from the last bit shifted out. Logic ops keep C. Compare updates the flags but asks for no register write.

Top module: `alu16_flags`

## Requirements
- R1: Op code 0 (add) gives `res_q = a + b` modulo 2^16. C is the carry out of bit 15, N is result bit 15, and Z is 1 exactly when the result is zero.
- R2: Op code 1 (add-with-carry) gives `a + b + C`, where C is the flag register value before the edge. Its flags follow the R1 rules.
- R3: Op codes 2 (and), 3 (or), 4 (xor) and 9 (one's complement of a) give the bitwise result. They leave C unchanged and set N and Z from the result.
- R4: Op codes 5 (shift left) and 6 (logical shift right) move a by the amount b, for amounts 1 to 15, filling with zeros. C becomes the last bit shifted out of a.
- R5: Op code 7 (arithmetic shift right) fills the vacated upper bits with copies of a[15]. C becomes the last bit shifted out.
- R6: For any shift with b = 0, the result equals a and C is unchanged. N and Z follow the result.
- R7: For a shift amount of 16 or more, logical shifts give 0 and arithmetic shift right gives 16 copies of a[15]. C is the last bit that would leave the word: a[0] for a left shift by 16, a[15] for a logical right shift by 16, 0 for logical shifts beyond 16, and a[15] for any arithmetic shift of 16 or more.
- R8: Op code 8 (negate) gives `-a` modulo 2^16. C is the carry out of bit 15, which is 1 only when a = 0. N and Z follow the result.
- R9: Op code 10 (compare) computes `d - a`. C is 1 when d >= a (unsigned, no borrow), and N and Z follow the difference. `res_q` shows the difference and `res_wr` is 0.
- R10: Synchronous reset clears `res_q`, `res_wr` and all three flags. Outside reset the flags change only on an edge where `flag_we` is 1.
- R11: Op codes 11 to 15 are reserved. They give `res_q = 0` and `res_wr = 0`, and they leave the flags unchanged even when `flag_we` is 1.
- R12: `res_wr` is 1 for op codes 0 to 9. All outputs update on the rising edge that samples the inputs, and stay steady between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code (see requirements) |
| opnd_a | input | 16 | First source operand; value shifted by shifts |
| opnd_b | input | 16 | Second source operand; shift amount for shifts |
| opnd_d | input | 16 | Old destination value, used by compare |
| flag_we | input | 1 | Allows the flag register to load on this edge |
| res_q | output | 16 | Registered result |
| res_wr | output | 1 | Registered request to write the result to a register |
| flag_c | output | 1 | Carry flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench targets the shift edges: amounts of 0, 15, 16, 17 and 256. A shifter that did not saturate the amount would wrap a large count modulo 16 and return a nonzero word. One that mishandled zero would clobber C. It also tests a carry chained from an add into a following add-with-carry, since a design that read the flags through a bypass instead of the register would add the wrong carry. Negate of zero and compare with equal, greater and lesser operands are covered, because an inverted borrow sense would flip C in every compare. Reserved codes with the flag write enabled, and arithmetic with the flag write disabled, show whether a design lets the flags move when they must hold.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_ASR = 4'd7,
    OP_NEG = 4'd8,
    OP_NOT = 4'd9,
    OP_CMP = 4'd10
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic n;
    logic z;
  } alu_flags_t;

  typedef enum logic [1:0] {
    FCLS_ARITH = 2'd0,
    FCLS_LOGIC = 2'd1,
    FCLS_SHIFT = 2'd2,
    FCLS_NONE  = 2'd3
  } flag_class_e;

  function automatic flag_class_e op_class(input logic [3:0] op);
    case (op)
      OP_ADD, OP_ADC, OP_NEG, OP_CMP:  return FCLS_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_NOT:   return FCLS_LOGIC;
      OP_SHL, OP_SHR, OP_ASR:          return FCLS_SHIFT;
      default:                         return FCLS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] d,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int EW = WIDTH + 1;

  logic [EW-1:0] lhs;
  logic [EW-1:0] rhs;
  logic [EW-1:0] inc;
  logic [EW-1:0] total;

  // One adder shared by add, add-with-carry, negate and compare
  always_comb begin
    lhs = '0;
    rhs = '0;
    inc = '0;
    case (op)
      OP_ADD: begin
        lhs = {1'b0, a};
        rhs = {1'b0, b};
      end
      OP_ADC: begin
        lhs = {1'b0, a};
        rhs = {1'b0, b};
        inc = {{WIDTH{1'b0}}, cin};
      end
      OP_NEG: begin
        rhs = {1'b0, ~a};
        inc = {{WIDTH{1'b0}}, 1'b1};
      end
      OP_CMP: begin
        lhs = {1'b0, d};
        rhs = {1'b0, ~a};
        inc = {{WIDTH{1'b0}}, 1'b1};
      end
      default: begin
        lhs = '0;
      end
    endcase
    total = lhs + rhs + inc;
    sum   = total[WIDTH-1:0];
    cout  = total[WIDTH];
  end

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] y,
  output logic             cout
);

  // Amounts above WIDTH+1 behave like WIDTH+1, so the count can saturate
  localparam int SAT = WIDTH + 1;
  localparam int AW  = $clog2(SAT + 1);

  logic [AW-1:0]       amt;
  logic                amt_zero;
  logic [WIDTH:0]      left_w;
  logic [WIDTH:0]      right_w;
  logic signed [WIDTH:0] arith_w;

  always_comb begin
    if (b > WIDTH'(SAT)) amt = AW'(SAT);
    else                 amt = b[AW-1:0];
  end

  assign amt_zero = (b == '0);

  // A guard bit beside the word catches the last bit that leaves it
  assign left_w  = {1'b0, a} << amt;
  assign right_w = {a, 1'b0} >> amt;
  assign arith_w = $signed({a, 1'b0}) >>> amt;

  always_comb begin
    y    = a;
    cout = cin;
    if (!amt_zero) begin
      case (op)
        OP_SHL: begin
          y    = left_w[WIDTH-1:0];
          cout = left_w[WIDTH];
        end
        OP_SHR: begin
          y    = right_w[WIDTH:1];
          cout = right_w[0];
        end
        OP_ASR: begin
          y    = arith_w[WIDTH:1];
          cout = arith_w[0];
        end
        default: begin
          y    = a;
          cout = cin;
        end
      endcase
    end
  end

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [WIDTH-1:0] opnd_d,
  input  logic             flag_we,
  output logic [WIDTH-1:0] res_q,
  output logic             res_wr,
  output logic             flag_c,
  output logic             flag_n,
  output logic             flag_z
);

  alu_flags_t  flags_q;
  alu_flags_t  flags_nx;
  flag_class_e fcls;

  logic [WIDTH-1:0] arith_y;
  logic [WIDTH-1:0] logic_y;
  logic [WIDTH-1:0] shift_y;
  logic             arith_c;
  logic             shift_c;
  logic [WIDTH-1:0] res_nx;
  logic             wr_nx;

  alu16_arith #(.WIDTH(WIDTH)) u_arith (
    .op   (op_sel),
    .a    (opnd_a),
    .b    (opnd_b),
    .d    (opnd_d),
    .cin  (flags_q.c),
    .sum  (arith_y),
    .cout (arith_c)
  );

  alu16_logic #(.WIDTH(WIDTH)) u_logic (
    .op (op_sel),
    .a  (opnd_a),
    .b  (opnd_b),
    .y  (logic_y)
  );

  alu16_shift #(.WIDTH(WIDTH)) u_shift (
    .op   (op_sel),
    .a    (opnd_a),
    .b    (opnd_b),
    .cin  (flags_q.c),
    .y    (shift_y),
    .cout (shift_c)
  );

  assign fcls = op_class(op_sel);

  always_comb begin
    res_nx   = '0;
    wr_nx    = 1'b0;
    flags_nx = flags_q;
    case (fcls)
      FCLS_ARITH: begin
        res_nx = arith_y;
        wr_nx  = (op_sel != OP_CMP);
        flags_nx.c = arith_c;
      end
      FCLS_LOGIC: begin
        res_nx = logic_y;
        wr_nx  = 1'b1;
      end
      FCLS_SHIFT: begin
        res_nx = shift_y;
        wr_nx  = 1'b1;
        flags_nx.c = shift_c;
      end
      default: begin
        res_nx = '0;
        wr_nx  = 1'b0;
      end
    endcase
    if (fcls != FCLS_NONE) begin
      flags_nx.n = res_nx[WIDTH-1];
      flags_nx.z = (res_nx == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      res_wr  <= 1'b0;
      flags_q <= '0;
    end else begin
      res_q  <= res_nx;
      res_wr <= wr_nx;
      if (flag_we) flags_q <= flags_nx;
    end
  end

  assign flag_c = flags_q.c;
  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (flags_q == '0 && !res_wr && res_q == '0)); // R10
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst) !flag_we |=> $stable(flags_q)); // R10
  AST_ADD_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst) (flag_we && op_sel == OP_ADD) |=> (flag_z == (res_q == '0) && flag_n == res_q[WIDTH-1])); // R1
  AST_LOGIC_KEEP_C: assert property (@(posedge clk) disable iff (rst) (flag_we && fcls == FCLS_LOGIC) |=> (flag_c == $past(flag_c))); // R3
  AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (rst) (fcls == FCLS_SHIFT && opnd_b == '0) |=> (res_q == $past(opnd_a) && flag_c == $past(flag_c))); // R6
  AST_NEG_CARRY: assert property (@(posedge clk) disable iff (rst) (flag_we && op_sel == OP_NEG) |=> (flag_c == ($past(opnd_a) == '0))); // R8
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (op_sel == OP_CMP) |=> !res_wr); // R9
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst) (op_sel > OP_CMP) |=> (!res_wr && res_q == '0 && flags_q == $past(flags_q))); // R11

endmodule

// File: tb/tb_alu16_flags.sv
module tb_alu16_flags;

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] d;
    logic        cin;
    logic [15:0] res;
    logic        wr;
    logic        c;
    logic        n;
    logic        z;
  } vec_t;

  localparam int NV = 28;

  localparam vec_t VECS [NV] = '{
    '{4'd1,  4'd0,  16'h1234, 16'h0001, 16'h0000, 1'b0, 16'h1235, 1'b1, 1'b0, 1'b0, 1'b0}, // R1
    '{4'd1,  4'd0,  16'hFFFF, 16'h0001, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1}, // R1
    '{4'd1,  4'd0,  16'h7FFF, 16'h0001, 16'h0000, 1'b0, 16'h8000, 1'b1, 1'b0, 1'b1, 1'b0}, // R1
    '{4'd2,  4'd1,  16'h0001, 16'h0001, 16'h0000, 1'b1, 16'h0003, 1'b1, 1'b0, 1'b0, 1'b0}, // R2
    '{4'd2,  4'd1,  16'hFFFF, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1}, // R2
    '{4'd3,  4'd2,  16'hF0F0, 16'h0FF0, 16'h0000, 1'b1, 16'h00F0, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
    '{4'd3,  4'd3,  16'h8000, 16'h0001, 16'h0000, 1'b0, 16'h8001, 1'b1, 1'b0, 1'b1, 1'b0}, // R3
    '{4'd3,  4'd4,  16'hAAAA, 16'hAAAA, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1}, // R3
    '{4'd3,  4'd9,  16'h00FF, 16'h0000, 16'h0000, 1'b0, 16'hFF00, 1'b1, 1'b0, 1'b1, 1'b0}, // R3
    '{4'd4,  4'd5,  16'h8001, 16'h0001, 16'h0000, 1'b0, 16'h0002, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
    '{4'd4,  4'd5,  16'h0003, 16'h000F, 16'h0000, 1'b0, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b0}, // R4
    '{4'd4,  4'd6,  16'h0003, 16'h0001, 16'h0000, 1'b0, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
    '{4'd4,  4'd6,  16'h8000, 16'h0004, 16'h0000, 1'b1, 16'h0800, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
    '{4'd5,  4'd7,  16'h8004, 16'h0002, 16'h0000, 1'b0, 16'hE001, 1'b1, 1'b0, 1'b1, 1'b0}, // R5
    '{4'd5,  4'd7,  16'h4003, 16'h0001, 16'h0000, 1'b0, 16'h2001, 1'b1, 1'b1, 1'b0, 1'b0}, // R5
    '{4'd6,  4'd5,  16'h1234, 16'h0000, 16'h0000, 1'b1, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b0}, // R6
    '{4'd6,  4'd6,  16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R6
    '{4'd7,  4'd5,  16'h0001, 16'h0010, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1}, // R7
    '{4'd7,  4'd6,  16'h8000, 16'h0010, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1}, // R7
    '{4'd7,  4'd6,  16'hFFFF, 16'h0011, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R7
    '{4'd7,  4'd7,  16'h8000, 16'h0100, 16'h0000, 1'b0, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b0}, // R7
    '{4'd7,  4'd7,  16'h7FFF, 16'h0014, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1}, // R7
    '{4'd8,  4'd8,  16'h0001, 16'h0000, 16'h0000, 1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0}, // R8
    '{4'd8,  4'd8,  16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1}, // R8
    '{4'd9,  4'd10, 16'h0003, 16'h0000, 16'h0005, 1'b0, 16'h0002, 1'b0, 1'b1, 1'b0, 1'b0}, // R9
    '{4'd9,  4'd10, 16'h0005, 16'h0000, 16'h0003, 1'b1, 16'hFFFE, 1'b0, 1'b0, 1'b1, 1'b0}, // R9
    '{4'd9,  4'd10, 16'h1234, 16'h0000, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1}, // R9
    '{4'd11, 4'd12, 16'h5555, 16'h1111, 16'h2222, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1}  // R11
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_sel = '0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [15:0] opnd_d = '0;
  logic        flag_we = 1'b0;
  logic [15:0] res_q;
  logic        res_wr;
  logic        flag_c;
  logic        flag_n;
  logic        flag_z;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  alu16_flags #(.WIDTH(16)) dut (
    .clk     (clk),
    .rst     (rst),
    .op_sel  (op_sel),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .opnd_d  (opnd_d),
    .flag_we (flag_we),
    .res_q   (res_q),
    .res_wr  (res_wr),
    .flag_c  (flag_c),
    .flag_n  (flag_n),
    .flag_z  (flag_z)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] d, input logic we);
    @(negedge clk);
    op_sel  = op;
    opnd_a  = a;
    opnd_b  = b;
    opnd_d  = d;
    flag_we = we;
    @(posedge clk);
    #1;
  endtask

  // Leaves flags at C=c, N=0, Z=1
  task automatic set_carry(input logic c);
    if (c) run_op(4'd8, 16'h0000, 16'h0000, 16'h0000, 1'b1);
    else   run_op(4'd0, 16'h0000, 16'h0000, 16'h0000, 1'b1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check("R10 reset res_q", res_q, 16'h0000);
    check("R10 reset res_wr", {15'd0, res_wr}, 16'd0);
    check("R10 reset flags", {13'd0, flag_c, flag_n, flag_z}, 16'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      set_carry(VECS[i].cin);
      run_op(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].d, 1'b1);
      check($sformatf("R%0d vec %0d result", VECS[i].req, i), res_q, VECS[i].res);
      check($sformatf("R%0d vec %0d write", VECS[i].req, i), {15'd0, res_wr}, {15'd0, VECS[i].wr});
      check($sformatf("R%0d vec %0d flags", VECS[i].req, i), {13'd0, flag_c, flag_n, flag_z},
            {13'd0, VECS[i].c, VECS[i].n, VECS[i].z});
    end

    // R10: flag write disabled holds flags across an overflowing add
    set_carry(1'b0);
    run_op(4'd0, 16'h8000, 16'h8000, 16'h0000, 1'b0);
    check("R10 no-we result", res_q, 16'h0000);
    check("R10 no-we flags held", {13'd0, flag_c, flag_n, flag_z}, 16'b001);

    // R2: carry chained from add into add-with-carry
    run_op(4'd0, 16'hFFFF, 16'h0002, 16'h0000, 1'b1);
    check("R2 chain first sum", res_q, 16'h0001);
    check("R2 chain carry", {15'd0, flag_c}, 16'd1);
    run_op(4'd1, 16'h0000, 16'h0000, 16'h0000, 1'b1);
    check("R2 chain adc result", res_q, 16'h0001);
    check("R2 chain adc flags", {13'd0, flag_c, flag_n, flag_z}, 16'b000);

    // R11: reserved code 15 with write enabled keeps C=1
    set_carry(1'b1);
    run_op(4'd15, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1);
    check("R11 code15 result", res_q, 16'h0000);
    check("R11 code15 flags", {13'd0, flag_c, flag_n, flag_z}, 16'b101);

    // R12: outputs change only on the edge
    @(negedge clk);
    op_sel = 4'd0; opnd_a = 16'h0100; opnd_b = 16'h0023; opnd_d = 16'h0000; flag_we = 1'b1;
    #2;
    check("R12 before edge result", res_q, 16'h0000);
    check("R12 before edge write", {15'd0, res_wr}, 16'd0);
    @(posedge clk);
    #1;
    check("R12 after edge result", res_q, 16'h0123);
    check("R12 after edge write", {15'd0, res_wr}, 16'd1);

    // R10: reset in mid-run clears the flags
    run_op(4'd0, 16'h8000, 16'h8000, 16'h0000, 1'b1);
    check("R10 pre-reset flags", {13'd0, flag_c, flag_n, flag_z}, 16'b101);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R10 mid reset flags", {13'd0, flag_c, flag_n, flag_z}, 16'd0);
    check("R10 mid reset result", res_q, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    finish_run();
  end

endmodule